// File: doc/BRIEF.md
# D-Channel Access Blocking Controller

This block sits on the downstream direction of a time-multiplexed ISDN frame interface. In each frame it takes a single control indication, blocked or available, from a fixed position. It then shapes two signals that decide whether terminals may keep using the shared D-channel. The first is the echo bit sent back toward the subscriber bus. The second is a stop/go bit on the frame interface. While the channel is blocked, the echo carries the inverse of the subscriber D bit. Every terminal that is sending therefore sees a collision and drops its message. While the channel is available, the echo is a plain copy of the D bit.

There are two ways to read the indication, chosen by a mode input. In bit mode, one bit of the downstream frame gives the state directly. In code mode, a 4-bit command/indicate code in the same byte gives the state. Code mode needs the same code in two frames in a row before the state changes. A status output shows the current state to a host.

The block runs on a fast system clock. It samples the frame sync and data clock as ordinary synchronous inputs, so the frame timing is recovered from edges of these two signals.

Top module: `dch_block_ctl`

## Requirements
- R1: After reset the block reports blocked (status 0, stop/go 1). It stays blocked until the first control indication is taken.
- R2: A frame begins at a rising edge of frame sync and holds 256 bits, sent most significant bit first. Each bit spans two data-clock periods. Data is taken at the second falling data-clock edge of the bit. The control bit is frame bit 90: channel 2, byte 3 of that channel, bit weight 5.
- R3: In bit mode (code_mode = 0), a control bit of 1 gives available and a control bit of 0 gives blocked.
- R4: While blocked, echo_o equals the inverse of sub_d_i in the same cycle.
- R5: While available, echo_o equals sub_d_i and stop_go_o is 0.
- R6: While blocked, stop_go_o is 1.
- R7: The state changes only at the end of the control byte. The new state appears three system-clock cycles after the falling data-clock edge that samples frame bit 95. It is then held until the next end of the control byte.
- R8: In code mode (code_mode = 1), the code is byte bits 5 down to 2, which are frame bits 90 to 93 with the code MSB first. Code 1100 gives blocked and code 1000 gives available.
- R9: In code mode, a code changes the state only when the previous frame carried the same code.
- R10: In code mode, any code other than 1100 or 1000 leaves the state unchanged.
- R11: d_avail_o is 1 exactly when the block is in the available state.
- R12: Frame bits outside the control field have no effect on the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| code_mode | input | 1 | 0 selects bit mode, 1 selects command/indicate code mode |
| fsc_i | input | 1 | Frame sync; its rising edge starts a frame |
| dcl_i | input | 1 | Data clock at twice the bit rate |
| dd_i | input | 1 | Downstream serial data |
| sub_d_i | input | 1 | D bit currently received from the subscriber bus |
| echo_o | output | 1 | Echo bit toward the subscriber bus |
| stop_go_o | output | 1 | Stop/go indication, high while blocked |
| d_avail_o | output | 1 | Status: 1 while the D-channel is available |

## Verification
Two functions can fall in the same system-clock cycle. One is the state update at the end of the control byte. The other is a change of the subscriber D bit, which moves the echo directly. The bench gives sub_d_i a new pseudo-random value on every cycle, so the D bit also changes in the exact cycle the state flips. A cycle-accurate model in the bench updates its expected state three cycles after the sampling data-clock edge. Every cycle, the bench compares echo, stop/go and status against that model, so a polarity switch that comes one cycle early or late, or that takes a stale D bit, is caught.

// File: rtl/dch_pkg.sv
// Package: shared constants and types for the D-channel blocking controller.
// Assumes a 4-bit command/indicate field.
package dch_pkg;

    // Width of the command/indicate field in code mode.
    localparam int CI_W = 4;

    // Code value that blocks the D-channel.
    localparam logic [CI_W-1:0] CI_BLOCKED = 4'b1100;

    // Code value that frees the D-channel.
    localparam logic [CI_W-1:0] CI_FREE    = 4'b1000;

    // Which of the two data-clock periods of a bit is under way.
    typedef enum logic {
        HALF_FIRST  = 1'b0,
        HALF_SECOND = 1'b1
    } bit_half_t;

endpackage

// File: rtl/dch_frame_timer.sv
// Module: dch_frame_timer
// Recovers the bit timing of the downstream frame.
// Takes fsc_i and dcl_i as synchronous samples of the system clock and
// issues one strobe for each frame bit, with the bit's index and value.
// Assumes: the data clock runs at twice the bit rate, the frame-sync rise
// coincides with a data-clock rise, and data is stable across the
// second falling data-clock edge of each bit. Bits past the last are ignored
// until the next frame-sync rise.
module dch_frame_timer
    import dch_pkg::*;
#(
    parameter int FRAME_BITS = 256,
    parameter int CW         = $clog2(FRAME_BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fsc_i,
    input  logic          dcl_i,
    input  logic          dd_i,
    output logic          bit_stb,
    output logic [CW-1:0] bit_idx,
    output logic          bit_val
);

    localparam logic [CW-1:0] LAST_IDX = CW'(FRAME_BITS - 1);

    logic          dcl_q;
    logic          fsc_q;
    logic          live;
    bit_half_t     half;
    logic [CW-1:0] cnt;
    logic          dcl_fall;
    logic          fsc_rise;

    // Edge detection on the sampled frame sync and data clock.
    always_comb begin
        dcl_fall = dcl_q & ~dcl_i;
        fsc_rise = fsc_i & ~fsc_q;
    end

    // Bit counter: restart on frame sync, strobe on second falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dcl_q   <= 1'b0;
            fsc_q   <= 1'b0;
            live    <= 1'b0;
            half    <= HALF_FIRST;
            cnt     <= '0;
            bit_stb <= 1'b0;
            bit_idx <= '0;
            bit_val <= 1'b0;
        end else begin
            dcl_q   <= dcl_i;
            fsc_q   <= fsc_i;
            bit_stb <= 1'b0;
            if (fsc_rise) begin
                cnt  <= '0;
                half <= HALF_FIRST;
                live <= 1'b1;
            end else if (live && dcl_fall) begin
                if (half == HALF_FIRST) begin
                    half <= HALF_SECOND;
                end else begin
                    half    <= HALF_FIRST;
                    bit_stb <= 1'b1;
                    bit_idx <= cnt;
                    bit_val <= dd_i;
                    if (cnt == LAST_IDX) begin
                        live <= 1'b0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            end
        end
    end

    // R2: a bit spans two falling edges, so strobes are never back to back.
    a_r2_strobe_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |=> !bit_stb);

endmodule

// File: rtl/dch_slot_capture.sv
// Module: dch_slot_capture
// Picks the control bit and the command/indicate field out of the control
// byte. It publishes both, with a one-cycle update pulse, when the byte's
// last bit arrives.
// Assumes: both fields end before the last bit of the byte (lowest used
// bit weight >= 1), and bits arrive most significant first.
module dch_slot_capture
    import dch_pkg::*;
#(
    parameter int CW         = 8,
    parameter int SLOT_FIRST = 88,
    parameter int CTRL_BIT   = 5,
    parameter int CODE_MSB   = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bit_stb,
    input  logic [CW-1:0]   bit_idx,
    input  logic            bit_val,
    output logic            upd,
    output logic            ctrl_o,
    output logic [CI_W-1:0] code_o
);

    localparam int SLOT_LAST  = SLOT_FIRST + 7;
    localparam int CTRL_POS   = SLOT_FIRST + 7 - CTRL_BIT;
    localparam int CODE_FIRST = SLOT_FIRST + 7 - CODE_MSB;
    localparam int CODE_LAST  = CODE_FIRST + CI_W - 1;

    logic            ctrl_sh;
    logic [CI_W-1:0] code_sh;
    logic            in_code;

    // Marks strobes that fall inside the code field.
    always_comb begin
        in_code = (bit_idx >= CW'(CODE_FIRST)) && (bit_idx <= CW'(CODE_LAST));
    end

    // Gather the field bits and publish them at the end of the byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_sh <= 1'b0;
            code_sh <= '0;
            upd     <= 1'b0;
            ctrl_o  <= 1'b0;
            code_o  <= '0;
        end else begin
            upd <= 1'b0;
            if (bit_stb) begin
                if (bit_idx == CW'(CTRL_POS)) begin
                    ctrl_sh <= bit_val;
                end
                if (in_code) begin
                    code_sh <= {code_sh[CI_W-2:0], bit_val};
                end
                if (bit_idx == CW'(SLOT_LAST)) begin
                    upd    <= 1'b1;
                    ctrl_o <= ctrl_sh;
                    code_o <= code_sh;
                end
            end
        end
    end

    // R7: an update pulse always follows the strobe of the byte's last bit.
    a_r7_publish_at_byte_end: assert property (@(posedge clk) disable iff (!rst_n)
        upd |-> $past(bit_stb && (bit_idx == CW'(SLOT_LAST))));

endmodule

// File: rtl/dch_access_state.sv
// Module: dch_access_state
// Holds the blocked/available state. Bit mode takes the control bit as it
// is. Code mode accepts 1100 or 1000 only when the same code was seen in
// the previous frame.
// Assumes: upd pulses once per frame. Reset leaves the state blocked and
// clears the code history.
module dch_access_state
    import dch_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            code_mode,
    input  logic            upd,
    input  logic            ctrl_i,
    input  logic [CI_W-1:0] code_i,
    output logic            avail
);

    logic [CI_W-1:0] prev_code;
    logic            prev_ok;
    logic            repeat_hit;

    // A code counts only when it repeats the previous frame's code.
    always_comb begin
        repeat_hit = prev_ok && (code_i == prev_code);
    end

    // State update once per frame, at the end of the control byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            avail     <= 1'b0;
            prev_code <= '0;
            prev_ok   <= 1'b0;
        end else if (upd) begin
            if (code_mode) begin
                prev_code <= code_i;
                prev_ok   <= 1'b1;
                if (repeat_hit && code_i == CI_BLOCKED) begin
                    avail <= 1'b0;
                end else if (repeat_hit && code_i == CI_FREE) begin
                    avail <= 1'b1;
                end
            end else begin
                avail   <= ctrl_i;
                prev_ok <= 1'b0;
            end
        end
    end

    // R7: the state moves only right after an update pulse.
    a_r7_change_on_update: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(avail) |-> $past(upd));

    // R9: a code that does not repeat the previous one changes nothing.
    a_r9_needs_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && code_mode && !(prev_ok && code_i == prev_code)) |=> $stable(avail));

    // R10: codes other than the two defined ones change nothing.
    a_r10_other_codes: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && code_mode && code_i != CI_BLOCKED && code_i != CI_FREE) |=> $stable(avail));

endmodule

// File: rtl/dch_block_ctl.sv
// Module: dch_block_ctl (top)
// D-channel access blocking controller. Reads the blocked/available
// indication from the downstream frame and forces the echo bit and the
// stop/go bit so that terminals abandon transmission while blocked.
// Assumes: all inputs are synchronous to clk. code_mode is static between
// resets.
module dch_block_ctl
    import dch_pkg::*;
#(
    parameter int CHANNELS   = 8,
    parameter int CH_BYTES   = 4,
    parameter int CTRL_CH    = 2,
    parameter int CTRL_BYTE  = 3,
    parameter int CTRL_BIT   = 5,
    parameter int CODE_MSB   = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic code_mode,
    input  logic fsc_i,
    input  logic dcl_i,
    input  logic dd_i,
    input  logic sub_d_i,
    output logic echo_o,
    output logic stop_go_o,
    output logic d_avail_o
);

    localparam int FRAME_BITS = CHANNELS * CH_BYTES * 8;
    localparam int CW         = $clog2(FRAME_BITS);
    localparam int SLOT_FIRST = (CTRL_CH * CH_BYTES + CTRL_BYTE) * 8;

    logic            bit_stb;
    logic [CW-1:0]   bit_idx;
    logic            bit_val;
    logic            upd;
    logic            ctrl_bit;
    logic [CI_W-1:0] code;
    logic            avail;

    dch_frame_timer #(
        .FRAME_BITS (FRAME_BITS),
        .CW         (CW)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .fsc_i   (fsc_i),
        .dcl_i   (dcl_i),
        .dd_i    (dd_i),
        .bit_stb (bit_stb),
        .bit_idx (bit_idx),
        .bit_val (bit_val)
    );

    dch_slot_capture #(
        .CW         (CW),
        .SLOT_FIRST (SLOT_FIRST),
        .CTRL_BIT   (CTRL_BIT),
        .CODE_MSB   (CODE_MSB)
    ) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_stb (bit_stb),
        .bit_idx (bit_idx),
        .bit_val (bit_val),
        .upd     (upd),
        .ctrl_o  (ctrl_bit),
        .code_o  (code)
    );

    dch_access_state u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .code_mode (code_mode),
        .upd       (upd),
        .ctrl_i    (ctrl_bit),
        .code_i    (code),
        .avail     (avail)
    );

    // Output shaping: invert the echo and raise stop/go while blocked.
    always_comb begin
        echo_o    = avail ? sub_d_i : ~sub_d_i;
        stop_go_o = ~avail;
        d_avail_o = avail;
    end

    // R4: while stop/go is raised, the echo always differs from the D bit.
    a_r4_forced_collision: assert property (@(posedge clk) disable iff (!rst_n)
        stop_go_o |-> (echo_o != sub_d_i));

    // R5: while available, the echo tracks the D bit.
    a_r5_transparent_echo: assert property (@(posedge clk) disable iff (!rst_n)
        d_avail_o |-> (echo_o == sub_d_i));

endmodule

// File: tb/tb_dch_block_ctl.sv
`timescale 1ns/1ps
module tb_dch_block_ctl;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic code_mode = 1'b0;
    logic fsc = 1'b0;
    logic dcl = 1'b0;
    logic dd = 1'b0;
    logic sub_d = 1'b0;
    logic echo, stop_go, status;

    int total = 0;
    int bad = 0;

    // Bench model state
    logic        exp_av = 1'b0;
    logic        nxt_av = 1'b0;
    logic        pend_av = 1'b0;
    int          pend = 0;
    logic [3:0]  m_prev = 4'b0;
    logic        m_prev_ok = 1'b0;
    logic [15:0] lf = 16'hACE1;

    always #2.5 clk = ~clk;

    dch_block_ctl dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .code_mode (code_mode),
        .fsc_i     (fsc),
        .dcl_i     (dcl),
        .dd_i      (dd),
        .sub_d_i   (sub_d),
        .echo_o    (echo),
        .stop_go_o (stop_go),
        .d_avail_o (status)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic act, input logic exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0b exp=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One system-clock step: drive at the falling edge, check 1 ns later.
    task automatic step(input logic f, input logic c, input logic d, input bit trig);
        logic e_echo;
        @(negedge clk);
        fsc = f;
        dcl = c;
        dd  = d;
        sub_d = lf[0];
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        if (pend > 0) begin
            pend--;
            if (pend == 0) exp_av = pend_av;
        end
        if (trig) begin
            pend = 3;          // R7: three cycles after the sampling edge
            pend_av = nxt_av;
        end
        #1;
        e_echo = exp_av ? sub_d : ~sub_d;
        chk(status == exp_av, "R11 R7", "status", status, exp_av);
        chk(echo == e_echo, exp_av ? "R5" : "R4", "echo", echo, e_echo);
        chk(stop_go == ~exp_av, exp_av ? "R5" : "R6", "stop_go", stop_go, ~exp_av);
    endtask

    task automatic do_reset(input logic mode);
        rst_n = 1'b0;
        code_mode = mode;
        exp_av = 1'b0;
        pend = 0;
        m_prev_ok = 1'b0;
        for (int k = 0; k < 4; k++) step(1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Model of the next state taken at the end of this frame's control byte.
    task automatic model_next(input logic [7:0] byt);
        logic [3:0] cd;
        cd = byt[5:2];
        if (!code_mode) begin
            nxt_av = byt[5];           // R3: bit weight 5 of the control byte
            m_prev_ok = 1'b0;
        end else begin
            nxt_av = exp_av;
            if (m_prev_ok && cd == m_prev) begin
                if (cd == 4'b1100) nxt_av = 1'b0;  // R8
                if (cd == 4'b1000) nxt_av = 1'b1;  // R8
            end
            m_prev = cd;
            m_prev_ok = 1'b1;
        end
    endtask

    // Send one full frame: 256 bits, control byte at frame bits 88..95.
    task automatic send_frame(input logic [7:0] byt, input logic [31:0] fill,
                              input string tag);
        logic [255:0] fv;
        for (int i = 0; i < 256; i++) fv[i] = fill[i % 32];
        for (int k = 0; k < 8; k++) fv[88 + 7 - k] = byt[k];
        model_next(byt);
        for (int i = 0; i < 256; i++) begin
            for (int q = 0; q < 4; q++) begin
                for (int s = 0; s < 2; s++) begin
                    step((i == 0) && (q == 0), (q == 0) || (q == 2), fv[i],
                         (i == 95) && (q == 3) && (s == 0));
                end
            end
        end
        chk(status == nxt_av, tag, "frame-end status", status, nxt_av);
    endtask

    task automatic t_reset;
        do_reset(1'b0);
        for (int k = 0; k < 6; k++) step(1'b0, 1'b0, 1'b0, 1'b0);
        chk(status == 1'b0, "R1", "status after reset", status, 1'b0);
        chk(stop_go == 1'b1, "R1", "stop_go after reset", stop_go, 1'b1);
    endtask

    task automatic t_bit_mode;
        do_reset(1'b0);
        send_frame(8'h20, 32'h0000_0000, "R3 R2");   // only bit 90 set -> available
        send_frame(8'hDF, 32'hFFFF_FFFF, "R3 R12");  // everything set except bit 90
        send_frame(8'hFF, 32'h5A5A_C3C3, "R3");      // back to available
        send_frame(8'h00, 32'hFFFF_FFFF, "R12");     // neighbours high, bit 90 low
    endtask

    task automatic t_code_mode;
        do_reset(1'b1);
        send_frame({2'b01, 4'b1000, 2'b10}, 32'h1234_5678, "R9");   // first sighting
        send_frame({2'b01, 4'b1000, 2'b10}, 32'h8765_4321, "R8");   // repeat -> available
        send_frame({2'b10, 4'b1100, 2'b01}, 32'hFFFF_0000, "R9");   // single block code
        send_frame({2'b00, 4'b1010, 2'b11}, 32'h0F0F_0F0F, "R10");
        send_frame({2'b00, 4'b1010, 2'b11}, 32'hF0F0_F0F0, "R10");  // repeated unknown code
        send_frame({2'b11, 4'b1100, 2'b00}, 32'h0000_FFFF, "R9");
        send_frame({2'b11, 4'b1100, 2'b00}, 32'hAAAA_5555, "R8");   // repeat -> blocked
        send_frame({2'b01, 4'b1000, 2'b10}, 32'h3333_CCCC, "R9");
        send_frame({2'b01, 4'b0000, 2'b10}, 32'hC3C3_3C3C, "R10");
        send_frame({2'b01, 4'b1000, 2'b10}, 32'h9999_6666, "R9");   // interrupted run
    endtask

    initial begin
        #800000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_bit_mode();
        t_code_mode();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule